// File: doc/BRIEF.md
# Latency-Hiding Warp Issue Scheduler

This block is a single-issue scheduler for a multithreaded streaming core. It keeps a fixed pool of warp contexts. Each warp stands for a group of 32 threads, and the scheduler tracks it as one unit. Every warp owns a short program of compute, load and store operations. The programs are written through a preload port while the scheduler is halted.

When `run` is high, the scheduler grants at most one ready warp per cycle, using a round-robin pointer. The granted warp issues its next instruction. A load puts its warp to sleep for a fixed memory latency, so a warp never has more than one load in flight. A store is treated as buffered, so its warp stays eligible. Moving from one warp to the next costs no cycles, because every context stays resident. Throughput therefore depends only on how many warps are ready.

The scheduler reports the issued warp and its operation with a valid strobe. It also keeps a running count of issued instructions and a count of idle cycles.

Top module: `warp_issue_sched`

## Requirements
- R1: At most one instruction is issued per cycle. A selection made in cycle t appears on `issue_valid`, `issue_warp` and `issue_op` after the following clock edge. `issue_warp` and `issue_op` hold their last values while `issue_valid` is low.
- R2: Only a ready warp is granted. A warp is ready when `run` is high, it still has instructions left, and it is not waiting on a load. No instruction issues while `run` is low.
- R3: After a warp issues a load (op code 1), its next instruction appears on the outputs exactly MEM_LAT+1 cycles after the load appeared, provided no other warp competes for the slot.
- R4: A store (op code 2) does not block its warp. A lone warp issues its next instruction in the cycle directly after the store.
- R5: A compute operation (op code 0, and op code 3, which is treated the same way) does not block its warp. A lone warp issues back to back.
- R6: Among the ready warps, the first one after the most recently issued warp wins, in increasing index order with wrap-around. After reset, warp 0 has the highest priority.
- R7: Switching warps costs nothing. While two or more warps are ready, `issue_valid` stays high on consecutive cycles and the warp index changes every cycle.
- R8: A warp that has issued its final instruction is never selected again. A warp with no preloaded program never issues. Each warp issues exactly as many instructions as its program length.
- R9: `issue_cnt` increases by one for every issued instruction. `stall_cnt` increases by one for every cycle in which `run` is high and nothing issues.
- R10: A preload write (`pl_we`) stores `pl_op` at slot `pl_idx` of warp `pl_warp` only while `run` is low. When `pl_last` is set, the program length of that warp becomes `pl_idx`+1. A write while `run` is high is ignored.
- R11: After reset, `issue_valid` is 0, `issue_warp` is 0, `issue_op` is 0, both counters are 0, and every warp is empty and done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-stage synchronizer |
| run | input | 1 | Scheduler enable; preload is accepted only while low |
| pl_we | input | 1 | Preload write strobe |
| pl_warp | input | $clog2(NUM_WARPS) | Warp selected for the preload |
| pl_idx | input | $clog2(PROG_LEN) | Instruction slot within the program |
| pl_op | input | 2 | Operation: 0 compute, 1 load, 2 store, 3 compute |
| pl_last | input | 1 | Marks this slot as the final instruction of the warp |
| issue_valid | output | 1 | An instruction issued in the previous cycle |
| issue_warp | output | $clog2(NUM_WARPS) | Warp that issued |
| issue_op | output | 2 | Operation that issued |
| issue_cnt | output | CNT_W | Total number of issued instructions |
| stall_cnt | output | CNT_W | Number of cycles with `run` high and no issue |

## Verification
Every issue output and both counters are due on the clock edge that follows the cycle in which the stimulus is applied. The bench drives inputs on the falling edge. It steps a reference model through that same cycle, then compares all outputs on the next falling edge, so each result is checked in the one cycle where it becomes valid. Load gaps and the round-robin order are measured from a log of issue cycles. The log is compared against the MEM_LAT+1 spacing and the expected warp order. Writes ignored during `run` are checked by watching the issue outputs for the instruction those writes would have added.

// File: rtl/wis_pkg.sv
package wis_pkg;
  typedef enum logic [1:0] {
    OP_CMP   = 2'd0,
    OP_LOAD  = 2'd1,
    OP_STORE = 2'd2,
    OP_RSVD  = 2'd3
  } op_e;
endpackage

// File: rtl/wis_warp_ctx.sv
module wis_warp_ctx
  import wis_pkg::*;
#(
  parameter int PROG_LEN = 8,
  parameter int MEM_LAT  = 400,
  localparam int IDX_W = (PROG_LEN > 1) ? $clog2(PROG_LEN) : 1,
  localparam int PC_W  = $clog2(PROG_LEN + 1),
  localparam int LAT_W = $clog2(MEM_LAT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             pl_we,
  input  logic [IDX_W-1:0] pl_idx,
  input  logic [1:0]       pl_op,
  input  logic             pl_last,
  input  logic             grant,
  output logic             ready,
  output logic [1:0]       cur_op
);

  op_e              prog_q [PROG_LEN];
  logic [PC_W-1:0]  len_q, len_d;
  logic [PC_W-1:0]  pc_q, pc_d;
  logic [LAT_W-1:0] wait_q, wait_d;
  logic             done;
  logic             prog_wr;
  op_e              op_now;

  assign prog_wr = pl_we && !run;
  assign done    = (pc_q >= len_q);
  assign ready   = run && !done && (wait_q == '0);

  always_comb begin
    op_now = OP_CMP;
    if (int'(pc_q) < PROG_LEN) op_now = prog_q[pc_q[IDX_W-1:0]];
  end
  assign cur_op = op_now;

  always_comb begin
    len_d  = len_q;
    pc_d   = pc_q;
    wait_d = wait_q;
    if (prog_wr && pl_last) len_d = PC_W'(pl_idx) + PC_W'(1);
    if (grant) begin
      pc_d   = pc_q + PC_W'(1);
      wait_d = (op_now == OP_LOAD) ? LAT_W'(MEM_LAT) : '0;
    end else if (wait_q != '0) begin
      wait_d = wait_q - LAT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q  <= '0;
      pc_q   <= '0;
      wait_q <= '0;
    end else begin
      len_q  <= len_d;
      pc_q   <= pc_d;
      wait_q <= wait_d;
    end
  end

  always_ff @(posedge clk) begin
    if (prog_wr) prog_q[pl_idx] <= op_e'(pl_op);
  end

  p_load_sleeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && op_now == OP_LOAD) |=> !ready);
  p_wait_counts_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_q != '0 && !grant) |=> (wait_q == $past(wait_q) - LAT_W'(1)));
  p_store_no_block_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && op_now == OP_STORE) |=> (wait_q == '0));
  p_done_not_granted_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !grant);

endmodule

// File: rtl/wis_rr_arb.sv
module wis_rr_arb #(
  parameter int N = 4,
  localparam int W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0] req,
  input  logic [W-1:0] last,
  output logic         gnt_vld,
  output logic [W-1:0] gnt_idx,
  output logic [N-1:0] gnt_vec
);

  always_comb begin
    int cand;
    gnt_vld = 1'b0;
    gnt_idx = '0;
    for (int i = 1; i <= N; i++) begin
      cand = (int'(last) + i) % N;
      if (!gnt_vld && req[cand]) begin
        gnt_vld = 1'b1;
        gnt_idx = W'(cand);
      end
    end
  end

  always_comb begin
    for (int i = 0; i < N; i++) gnt_vec[i] = gnt_vld && (int'(gnt_idx) == i);
  end

endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched #(
  parameter int NUM_WARPS = 4,
  parameter int PROG_LEN  = 8,
  parameter int MEM_LAT   = 400,
  parameter int CNT_W     = 32,
  localparam int WID_W = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1,
  localparam int IDX_W = (PROG_LEN > 1) ? $clog2(PROG_LEN) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             pl_we,
  input  logic [WID_W-1:0] pl_warp,
  input  logic [IDX_W-1:0] pl_idx,
  input  logic [1:0]       pl_op,
  input  logic             pl_last,
  output logic             issue_valid,
  output logic [WID_W-1:0] issue_warp,
  output logic [1:0]       issue_op,
  output logic [CNT_W-1:0] issue_cnt,
  output logic [CNT_W-1:0] stall_cnt
);

  logic [1:0]           rst_pipe_q;
  logic                 rst_ni;
  logic [NUM_WARPS-1:0] ready_vec;
  logic [NUM_WARPS-1:0] gnt_vec;
  logic [1:0]           op_vec [NUM_WARPS];
  logic                 gnt_vld;
  logic [WID_W-1:0]     gnt_idx;
  logic [WID_W-1:0]     last_q, last_d;
  logic                 vld_q, vld_d;
  logic [WID_W-1:0]     warp_q;
  logic [1:0]           op_q, op_d;
  logic [CNT_W-1:0]     icnt_q, icnt_d;
  logic [CNT_W-1:0]     scnt_q, scnt_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_ni = rst_pipe_q[1];

  for (genvar g = 0; g < NUM_WARPS; g++) begin : g_warp
    wis_warp_ctx #(
      .PROG_LEN (PROG_LEN),
      .MEM_LAT  (MEM_LAT)
    ) u_ctx (
      .clk     (clk),
      .rst_n   (rst_ni),
      .run     (run),
      .pl_we   (pl_we && (int'(pl_warp) == g)),
      .pl_idx  (pl_idx),
      .pl_op   (pl_op),
      .pl_last (pl_last),
      .grant   (gnt_vec[g]),
      .ready   (ready_vec[g]),
      .cur_op  (op_vec[g])
    );
  end

  wis_rr_arb #(.N(NUM_WARPS)) u_arb (
    .req     (ready_vec),
    .last    (last_q),
    .gnt_vld (gnt_vld),
    .gnt_idx (gnt_idx),
    .gnt_vec (gnt_vec)
  );

  always_comb begin
    vld_d  = gnt_vld;
    last_d = last_q;
    op_d   = op_q;
    icnt_d = icnt_q;
    scnt_d = scnt_q;
    if (gnt_vld) begin
      last_d = gnt_idx;
      op_d   = op_vec[gnt_idx];
      icnt_d = icnt_q + CNT_W'(1);
    end else if (run) begin
      scnt_d = scnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      last_q <= WID_W'(NUM_WARPS - 1);
      warp_q <= '0;
      op_q   <= '0;
      icnt_q <= '0;
      scnt_q <= '0;
    end else begin
      vld_q  <= vld_d;
      icnt_q <= icnt_d;
      scnt_q <= scnt_d;
      if (gnt_vld) begin
        last_q <= last_d;
        warp_q <= gnt_idx;
        op_q   <= op_d;
      end
    end
  end

  assign issue_valid = vld_q;
  assign issue_warp  = warp_q;
  assign issue_op    = op_q;
  assign issue_cnt   = icnt_q;
  assign stall_cnt   = scnt_q;

  p_single_grant_r1: assert property (@(posedge clk) disable iff (!rst_ni)
    $onehot0(gnt_vec));
  p_grant_ready_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    ((gnt_vec & ~ready_vec) == '0));
  p_halt_no_issue_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    !run |=> !issue_valid);
  p_counters_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    issue_valid |-> $stable(stall_cnt));

endmodule

// File: tb/warp_issue_sched_tb_top.sv
module warp_issue_sched_tb_top;
  localparam int NW  = 4;
  localparam int PL  = 8;
  localparam int LAT = 20;
  localparam int CW  = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic run, pl_we, pl_last;
  logic [1:0] pl_warp;
  logic [2:0] pl_idx;
  logic [1:0] pl_op;
  logic issue_valid;
  logic [1:0] issue_warp, issue_op;
  logic [CW-1:0] issue_cnt, stall_cnt;

  always #5 clk = ~clk;

  warp_issue_sched #(.NUM_WARPS(NW), .PROG_LEN(PL), .MEM_LAT(LAT), .CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .run(run), .pl_we(pl_we), .pl_warp(pl_warp),
    .pl_idx(pl_idx), .pl_op(pl_op), .pl_last(pl_last), .issue_valid(issue_valid),
    .issue_warp(issue_warp), .issue_op(issue_op), .issue_cnt(issue_cnt),
    .stall_cnt(stall_cnt)
  );

  int n_chk = 0, n_bad = 0, cyc = 0;
  int m_prog [NW][PL];
  int m_len [NW], m_pc [NW], m_wait [NW], m_cnt [NW];
  int m_last, m_icnt, m_scnt;
  bit e_vld;
  int e_warp, e_op;
  int log_w [4096], log_c [4096], log_o [4096];
  int n_log;

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  function automatic bit model_idle();
    for (int w = 0; w < NW; w++) if (m_pc[w] < m_len[w]) return 1'b0;
    return 1'b1;
  endfunction

  task automatic model_reset();
    for (int w = 0; w < NW; w++) begin
      m_len[w] = 0; m_pc[w] = 0; m_wait[w] = 0; m_cnt[w] = 0;
    end
    m_last = NW - 1; m_icnt = 0; m_scnt = 0;
    e_vld = 0; e_warp = 0; e_op = 0; n_log = 0;
  endtask

  // one clock cycle: drive, step the model, compare on the next falling edge
  task automatic tick(input bit r, input bit we = 0, input int w = 0, input int idx = 0,
                      input int op = 0, input bit lst = 0);
    bit found;
    int pick;
    run = r; pl_we = we; pl_warp = 2'(w); pl_idx = 3'(idx); pl_op = 2'(op); pl_last = lst;
    found = 0; pick = 0;
    for (int i = 1; i <= NW; i++) begin
      int c;
      c = (m_last + i) % NW;
      if (!found && r && m_pc[c] < m_len[c] && m_wait[c] == 0) begin
        found = 1; pick = c;
      end
    end
    e_vld = found;
    if (found) begin
      e_warp = pick;
      e_op = m_prog[pick][m_pc[pick]];
      m_last = pick;
      m_icnt++;
    end else if (r) m_scnt++;
    for (int k = 0; k < NW; k++) begin
      if (found && k == pick) begin
        m_wait[k] = (e_op == 1) ? LAT : 0;
        m_pc[k]++;
        m_cnt[k]++;
      end else if (m_wait[k] > 0) m_wait[k]--;
    end
    if (we && !r) begin
      m_prog[w][idx] = op;
      if (lst) m_len[w] = idx + 1;
    end
    @(posedge clk);
    @(negedge clk);
    cyc++;
    check("R1 issue_valid", int'(issue_valid), int'(e_vld));
    check("R6 issue_warp", int'(issue_warp), e_warp);
    check("R1 issue_op", int'(issue_op), e_op);
    check("R9 issue_cnt", int'(issue_cnt), m_icnt % (1 << CW));
    check("R9 stall_cnt", int'(stall_cnt), m_scnt % (1 << CW));
    if (issue_valid && n_log < 4096) begin
      log_w[n_log] = int'(issue_warp); log_c[n_log] = cyc; log_o[n_log] = int'(issue_op);
      n_log++;
    end
  endtask

  task automatic do_reset();
    run = 0; pl_we = 0; pl_warp = 0; pl_idx = 0; pl_op = 0; pl_last = 0;
    rst_n = 0;
    model_reset();
    repeat (2) @(negedge clk);
    check("R11 reset valid", int'(issue_valid), 0);
    check("R11 reset warp", int'(issue_warp), 0);
    check("R11 reset op", int'(issue_op), 0);
    check("R11 reset issue_cnt", int'(issue_cnt), 0);
    check("R11 reset stall_cnt", int'(stall_cnt), 0);
    rst_n = 1;
    repeat (3) tick(0);
  endtask

  task automatic run_to_idle();
    int guard;
    guard = 0;
    while (!model_idle() && guard < 4000) begin
      tick(1);
      guard++;
    end
    repeat (3) tick(1);
  endtask

  initial begin
    int seen;
    void'($urandom(32'd20240611));

    // directed: lone warp, load / compute / store spacing
    do_reset();
    tick(1);
    check("R11 empty warps stall", int'(issue_valid), 0);
    tick(0, 1, 0, 0, 1, 0);
    tick(0, 1, 0, 1, 0, 0);
    tick(0, 1, 0, 2, 2, 0);
    tick(0, 1, 0, 3, 3, 1);
    n_log = 0;
    run_to_idle();
    check("R8 lone warp issue total", n_log, 4);
    if (n_log >= 4) begin
      check("R3 load wake gap", log_c[1] - log_c[0], LAT + 1);
      check("R5 compute back to back", log_c[2] - log_c[1], 1);
      check("R4 store back to back", log_c[3] - log_c[2], 1);
      check("R5 op code 3 issues as compute", log_o[3], 3);
    end

    // R10: write during run is dropped, write while halted is kept
    n_log = 0;
    tick(1, 1, 0, 4, 2, 1);
    repeat (5) tick(1);
    check("R10 write during run ignored", n_log, 0);
    tick(0, 1, 0, 4, 2, 1);
    repeat (3) tick(1);
    check("R10 write while halted kept", n_log, 1);
    if (n_log >= 1) check("R10 kept op", log_o[0], 2);

    // directed: three warps of compute, one empty warp
    do_reset();
    for (int w = 0; w < NW; w++) begin
      if (w != 2) for (int i = 0; i < 3; i++) tick(0, 1, w, i, 0, i == 2);
    end
    n_log = 0;
    run_to_idle();
    check("R8 empty warp skipped total", n_log, 9);
    for (int i = 0; i < 9 && i < n_log; i++) begin
      check("R6 round robin order", log_w[i], (i % 3 == 2) ? 3 : i % 3);
      if (i > 0) check("R7 zero cost switch", log_c[i] - log_c[i - 1], 1);
    end

    // directed: two warps with loads overlap each other
    do_reset();
    tick(0, 1, 0, 0, 1, 0);
    tick(0, 1, 0, 1, 0, 1);
    tick(0, 1, 1, 0, 1, 0);
    tick(0, 1, 1, 1, 0, 1);
    n_log = 0;
    run_to_idle();
    check("R7 loads of two warps overlap", n_log >= 2 ? log_c[1] - log_c[0] : -1, 1);
    check("R3 second warp wake", n_log >= 4 ? log_c[3] - log_c[1] : -1, LAT + 1);

    // random programs with random halts
    for (int s = 0; s < 24; s++) begin
      do_reset();
      for (int w = 0; w < NW; w++) begin
        int len;
        len = $urandom % (PL + 1);
        for (int i = 0; i < len; i++) tick(0, 1, w, i, $urandom % 4, i == len - 1);
      end
      seen = 0;
      while (!model_idle() && seen < 4000) begin
        tick(($urandom % 10) != 0);
        seen++;
      end
      repeat (2) tick(1);
      for (int w = 0; w < NW; w++) check("R8 per-warp issue total", m_cnt[w], m_len[w]);
    end

    report();
  end

  initial begin
    int wd;
    wd = 0;
    forever begin
      @(posedge clk);
      wd++;
      if (wd > 150000) begin
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual %0d cycles expected completion", wd);
        report();
      end
    end
  end

endmodule